// File: doc/BRIEF.md
# Two-Level Multiprocessor Interrupt Controller

This block gathers level-sensitive interrupt sources and presents one interrupt line to each of up to four CPUs. Every source has to pass two gates before it can reach a CPU. The first gate is a global enable bit for that source. The second gate is a mask bit that each CPU holds separately for that source. Software changes either bit by writing the source number to a set strobe or a clear strobe. There is no read-modify-write of a bitmap.

Sources 0 to 28 are private to each CPU. Source 0 carries a per-CPU inter-processor doorbell summary and source 1 carries a per-CPU message doorbell summary. The two gates alone decide whether one of these sources reaches a CPU. Sources 29 and above are shared. Each shared source also has a routing register that names the CPUs allowed to receive it.

Software uses a simple request port with two windows. The main window holds the controller-wide state. The per-CPU window is an alias, and the requester's CPU number chooses which copy is reached. Reading the acknowledge location of the per-CPU window returns the number of the lowest pending source for that CPU.

Top module: `irq_dual_gate_ctrl`

## Requirements
- R1: After reset, every global enable is clear, every per-CPU mask bit is set and every routing register reads 0. As a result, no `irq_o` bit is asserted, even when a source is active and its enable is later set.
- R2: A main-window write to offset 0x30 sets the global enable of the source whose number is in `req_wdata`. A write to offset 0x34 clears it. A number at or above NUM_SRC changes nothing.
- R3: A per-CPU-window write to offset 0x48 sets the mask of the written source for CPU `req_cpu` only. A write to offset 0x4C clears that mask bit.
- R4: The routing register of source n is at main offset 0x100+4n. Bits [NUM_CPUS-1:0] hold the normal-interrupt route, bit c for CPU c. Bits [8+NUM_CPUS-1:8] hold the fast-interrupt route. All other bits read as 0.
- R5: `irq_o[c]` is asserted for a shared source (number 29 or above) only when all four conditions hold: the source is active, its global enable is set, its mask for CPU c is clear and its route bit c is set.
- R6: For a per-CPU source (number 0 to 28), the routing register has no effect. The source reaches CPU c when it is active, its global enable is set and its mask for CPU c is clear.
- R7: For CPU c, source 0 is driven by `ipi_i[c]` and source 1 is driven by `msi_i[c]`.
- R8: A per-CPU-window read at offset 0x44 returns in bits [9:0] the lowest-numbered source pending for that CPU, or 1023 when nothing is pending. A read does not clear anything.
- R9: A main-window read at offset 0x00 returns NUM_SRC in bits [11:2] and 0 in all other bits.
- R10: A per-CPU-window read at offset 0x10 returns in bits [28:0] the raw active state of sources 0 to 28 as seen by the requesting CPU. Enables and masks do not affect this value.
- R11: Sources are level-sensitive. `irq_o` and the acknowledge value follow a source's level directly, and the `irq_o` bit drops in the same cycle the last qualifying source drops.
- R12: Read data appears on `rdata` in the cycle after the read request. `rdata` is 0 when the address is unmapped and in any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC-2 | Level inputs of sources 2 to NUM_SRC-1 |
| ipi_i | input | NUM_CPUS | Per-CPU inter-processor doorbell summary (source 0) |
| msi_i | input | NUM_CPUS | Per-CPU message doorbell summary (source 1) |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_percpu | input | 1 | 1 = per-CPU window, 0 = main window |
| req_cpu | input | CPU_W | Number of the requesting CPU |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| irq_o | output | NUM_CPUS | Interrupt line of each CPU |

## Verification
On every cycle, the assertions check four things:
- each set or clear strobe lands on exactly the source and the CPU that were written;
- a routing write is stored as written;
- each CPU's interrupt line agrees with its priority encoder having a winner;
- the acknowledge value is either a valid source number or 1023, and idle cycles return zero read data.

Only the bench's scenarios can show the rest. These are the reset gating with active sources, the ignored out-of-range index, the rule that a mask affects only the requesting CPU, route-based selection among CPUs, the routing register having no effect on private sources, lowest-number selection as sources drop away, and the contents of the cause and control words.

// File: rtl/irq_dg_pkg.sv
package irq_dg_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 10;
    localparam int PC_LAST = 28;
    localparam int PC_NUM  = PC_LAST + 1;
    localparam logic [IDX_W-1:0] NO_IRQ = 10'd1023;

    // main window offsets
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_ROUTE  = 12'h100;
    // per-CPU window offsets
    localparam logic [ADDR_W-1:0] OFF_CAUSE  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_MK_SET = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_MK_CLR = 12'h04C;
endpackage

// File: rtl/irq_dg_regs.sv
module irq_dg_regs
    import irq_dg_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CPUS = 4,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              percpu,
    input  logic [CPU_W-1:0]                  cpu,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic                              route_sel,
    output logic [SRC_W-1:0]                  route_idx,
    output logic [NUM_SRC-1:0]                gen_q,
    output logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q,
    output logic [NUM_SRC-1:0][NUM_CPUS-1:0]  rirq_q,
    output logic [NUM_SRC-1:0][NUM_CPUS-1:0]  rfiq_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0]               gen;
        logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0][NUM_CPUS-1:0] rirq;
        logic [NUM_SRC-1:0][NUM_CPUS-1:0] rfiq;
    } regs_t;

    regs_t s_d, s_q;
    logic [ADDR_W-1:0] roff;
    logic              idx_ok;
    logic [SRC_W-1:0]  widx;

    always_comb begin
        roff      = addr - OFF_ROUTE;
        route_sel = (addr >= OFF_ROUTE) && (addr[1:0] == 2'b00) &&
                    ({2'b00, roff[ADDR_W-1:2]} < ADDR_W'(NUM_SRC));
        route_idx = roff[SRC_W+1:2];
        idx_ok    = wdata < DATA_W'(NUM_SRC);
        widx      = wdata[SRC_W-1:0];

        s_d = s_q;
        if (wr_en) begin
            if (!percpu) begin
                if (addr == OFF_EN_SET && idx_ok) s_d.gen[widx] = 1'b1;
                if (addr == OFF_EN_CLR && idx_ok) s_d.gen[widx] = 1'b0;
                if (route_sel) begin
                    s_d.rirq[route_idx] = wdata[NUM_CPUS-1:0];
                    s_d.rfiq[route_idx] = wdata[8 +: NUM_CPUS];
                end
            end else begin
                if (addr == OFF_MK_SET && idx_ok) s_d.mask[cpu][widx] = 1'b1;
                if (addr == OFF_MK_CLR && idx_ok) s_d.mask[cpu][widx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.gen  <= '0;
            s_q.mask <= '1;
            s_q.rirq <= '0;
            s_q.rfiq <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gen_q  = s_q.gen;
    assign mask_q = s_q.mask;
    assign rirq_q = s_q.rirq;
    assign rfiq_q = s_q.rfiq;
endmodule

// File: rtl/irq_dg_gate.sv
module irq_dg_gate
    import irq_dg_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CPUS = 4
) (
    input  logic [NUM_SRC-1:2]                src_i,
    input  logic [NUM_CPUS-1:0]               ipi_i,
    input  logic [NUM_CPUS-1:0]               msi_i,
    input  logic [NUM_SRC-1:0]                gen,
    input  logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask,
    input  logic [NUM_SRC-1:0][NUM_CPUS-1:0]  rirq,
    output logic [NUM_CPUS-1:0][NUM_SRC-1:0]  pend,
    output logic [NUM_CPUS-1:0][PC_NUM-1:0]   cause
);
    logic [NUM_CPUS-1:0][NUM_SRC-1:0] act;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign act[c][0] = ipi_i[c];
        assign act[c][1] = msi_i[c];
        assign act[c][NUM_SRC-1:2] = src_i;
        assign cause[c] = act[c][PC_NUM-1:0];
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            if (n <= PC_LAST) begin : g_private
                assign pend[c][n] = act[c][n] & gen[n] & ~mask[c][n];
            end else begin : g_shared
                assign pend[c][n] = act[c][n] & gen[n] & ~mask[c][n] & rirq[n][c];
            end
        end
    end
endmodule

// File: rtl/irq_dg_pick.sv
module irq_dg_pick
    import irq_dg_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = NO_IRQ;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_dual_gate_ctrl.sv
module irq_dual_gate_ctrl
    import irq_dg_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CPUS = 4,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:2]  src_i,
    input  logic [NUM_CPUS-1:0] ipi_i,
    input  logic [NUM_CPUS-1:0] msi_i,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_percpu,
    input  logic [CPU_W-1:0]    req_cpu,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_CPUS-1:0] irq_o
);
    logic                              route_sel;
    logic [SRC_W-1:0]                  route_idx;
    logic [NUM_SRC-1:0]                gen_q;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q;
    logic [NUM_SRC-1:0][NUM_CPUS-1:0]  rirq_q;
    logic [NUM_SRC-1:0][NUM_CPUS-1:0]  rfiq_q;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0]  pend;
    logic [NUM_CPUS-1:0][PC_NUM-1:0]   cause;
    logic [NUM_CPUS-1:0]               found;
    logic [NUM_CPUS-1:0][IDX_W-1:0]    ack_idx;

    irq_dg_regs #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (req_valid & req_write),
        .percpu    (req_percpu),
        .cpu       (req_cpu),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .route_sel (route_sel),
        .route_idx (route_idx),
        .gen_q     (gen_q),
        .mask_q    (mask_q),
        .rirq_q    (rirq_q),
        .rfiq_q    (rfiq_q)
    );

    irq_dg_gate #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) gate_i (
        .src_i (src_i),
        .ipi_i (ipi_i),
        .msi_i (msi_i),
        .gen   (gen_q),
        .mask  (mask_q),
        .rirq  (rirq_q),
        .pend  (pend),
        .cause (cause)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_pick
        irq_dg_pick #(.NUM_SRC(NUM_SRC)) pick_i (
            .vec   (pend[c]),
            .found (found[c]),
            .idx   (ack_idx[c])
        );
        assign irq_o[c] = |pend[c];
    end

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (req_valid && !req_write) begin
            if (!req_percpu) begin
                if (req_addr == OFF_CTRL) begin
                    rdata_d[IDX_W+1:2] = IDX_W'(NUM_SRC);
                end else if (route_sel) begin
                    rdata_d[NUM_CPUS-1:0]  = rirq_q[route_idx];
                    rdata_d[8 +: NUM_CPUS] = rfiq_q[route_idx];
                end
            end else begin
                if (req_addr == OFF_CAUSE) rdata_d[PC_NUM-1:0] = cause[req_cpu];
                if (req_addr == OFF_ACK)   rdata_d[IDX_W-1:0]  = ack_idx[req_cpu];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/irq_dual_gate_chk.sv
module irq_dual_gate_chk
    import irq_dg_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CPUS = 4,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              req_valid,
    input logic                              req_write,
    input logic                              req_percpu,
    input logic [CPU_W-1:0]                  req_cpu,
    input logic [ADDR_W-1:0]                 req_addr,
    input logic [DATA_W-1:0]                 req_wdata,
    input logic [DATA_W-1:0]                 rdata,
    input logic [NUM_CPUS-1:0]               irq_o,
    input logic                              route_sel,
    input logic [SRC_W-1:0]                  route_idx,
    input logic [NUM_SRC-1:0]                gen_q,
    input logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q,
    input logic [NUM_SRC-1:0][NUM_CPUS-1:0]  rirq_q,
    input logic [NUM_CPUS-1:0]               found,
    input logic [NUM_CPUS-1:0][IDX_W-1:0]    ack_idx
);
    logic wr_main, wr_pc, idx_ok;
    assign wr_main = req_valid && req_write && !req_percpu;
    assign wr_pc   = req_valid && req_write && req_percpu;
    assign idx_ok  = req_wdata < DATA_W'(NUM_SRC);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_main && req_addr == OFF_EN_SET && idx_ok) |=> gen_q[$past(req_wdata[SRC_W-1:0])]);
    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_main && req_addr == OFF_EN_CLR && idx_ok) |=> !gen_q[$past(req_wdata[SRC_W-1:0])]);
    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pc && req_addr == OFF_MK_SET && idx_ok) |=> mask_q[$past(req_cpu)][$past(req_wdata[SRC_W-1:0])]);
    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pc && req_addr == OFF_MK_CLR && idx_ok) |=> !mask_q[$past(req_cpu)][$past(req_wdata[SRC_W-1:0])]);
    // R4
    route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_main && route_sel) |=> rirq_q[$past(route_idx)] == $past(req_wdata[NUM_CPUS-1:0]));
    // R12
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> rdata == '0);

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        // R8
        irq_ack_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] == found[c]);
        // R8
        ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            found[c] ? (ack_idx[c] < IDX_W'(NUM_SRC)) : (ack_idx[c] == NO_IRQ));
    end
endmodule

bind irq_dual_gate_ctrl irq_dual_gate_chk #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_percpu (req_percpu),
    .req_cpu    (req_cpu),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rdata      (rdata),
    .irq_o      (irq_o),
    .route_sel  (route_sel),
    .route_idx  (route_idx),
    .gen_q      (gen_q),
    .mask_q     (mask_q),
    .rirq_q     (rirq_q),
    .found      (found),
    .ack_idx    (ack_idx)
);

// File: tb/irq_dual_gate_ctrl_tb_top.sv
module irq_dual_gate_ctrl_tb_top;
    localparam int NS = 64;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:2] src_i = '0;
    logic [NC-1:0] ipi_i = '0;
    logic [NC-1:0] msi_i = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_percpu = 1'b0;
    logic [1:0]  req_cpu = '0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata;
    logic [NC-1:0] irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_dual_gate_ctrl #(.NUM_SRC(NS), .NUM_CPUS(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .ipi_i(ipi_i), .msi_i(msi_i),
        .req_valid(req_valid), .req_write(req_write), .req_percpu(req_percpu),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_i = '0; ipi_i = '0; msi_i = '0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input bit pc, input logic [1:0] cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_percpu = pc; req_cpu = cpu;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input bit pc, input logic [1:0] cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_percpu = pc; req_cpu = cpu; req_addr = a;
        @(negedge clk);
        d = rdata;
        req_valid = 1'b0;
    endtask

    function automatic logic [11:0] route_at(input int n);
        return 12'(12'h100 + 4 * n);
    endfunction

    task automatic t_reset_and_gates();
        logic [31:0] d;
        do_reset();
        chk("R1 irq after reset", 32'(irq_o), 0);
        rd(0, 0, route_at(40), d);
        chk("R1 route reset", d, 0);
        src_i[40] = 1'b1;
        wr(0, 0, 12'h030, 40);
        wr(0, 0, route_at(40), 32'h3);
        chk("R1 masks set at reset", 32'(irq_o), 0);
        wr(1, 0, 12'h04C, 40);
        chk("R3 unmask cpu0 only", 32'(irq_o), 32'h1);
        rd(1, 0, 12'h044, d);
        chk("R8 ack 40", d, 40);
        rd(1, 0, 12'h044, d);
        chk("R8 ack not cleared", d, 40);
        wr(1, 0, 12'h048, 40);
        chk("R3 mask again", 32'(irq_o), 0);
        wr(1, 0, 12'h04C, 40);
        wr(0, 0, 12'h034, 40);
        chk("R2 enable cleared", 32'(irq_o), 0);
    endtask

    task automatic t_index_range();
        logic [31:0] d;
        do_reset();
        ipi_i[0] = 1'b1;
        wr(1, 0, 12'h04C, 0);
        wr(0, 0, 12'h030, 64);
        chk("R2 out-of-range enable ignored", 32'(irq_o), 0);
        wr(0, 0, 12'h030, 0);
        chk("R7 ipi source 0", 32'(irq_o), 32'h1);
        rd(1, 0, 12'h044, d);
        chk("R8 ack 0", d, 0);
        ipi_i[0] = 1'b0;
        msi_i[0] = 1'b1;
        wr(0, 0, 12'h030, 1);
        wr(1, 0, 12'h04C, 1);
        rd(1, 0, 12'h044, d);
        chk("R7 msi source 1", d, 1);
    endtask

    task automatic t_routing();
        logic [31:0] d;
        do_reset();
        wr(0, 0, route_at(50), 32'h0000_0F0A);
        rd(0, 0, route_at(50), d);
        chk("R4 route readback", d, 32'h0F0A);
        wr(0, 0, route_at(50), 32'hFFFF_FFFF);
        rd(0, 0, route_at(50), d);
        chk("R4 route unused bits", d, 32'h0F0F);
        wr(0, 0, route_at(50), 32'h0000_000A);
        src_i[50] = 1'b1;
        wr(0, 0, 12'h030, 50);
        for (int c = 1; c < 4; c++) wr(1, 2'(c), 12'h04C, 50);
        chk("R5 shared route cpu1,3", 32'(irq_o), 32'hA);
    endtask

    task automatic t_private();
        logic [31:0] d;
        do_reset();
        src_i[5] = 1'b1;
        wr(0, 0, 12'h030, 5);
        wr(1, 2, 12'h04C, 5);
        chk("R6 private ignores route", 32'(irq_o), 32'h4);
        rd(1, 2, 12'h044, d);
        chk("R6 ack cpu2", d, 5);
    endtask

    task automatic t_priority_level();
        logic [31:0] d;
        do_reset();
        src_i[33] = 1'b1; src_i[45] = 1'b1; src_i[60] = 1'b1;
        wr(0, 0, 12'h030, 33); wr(0, 0, 12'h030, 45); wr(0, 0, 12'h030, 60);
        wr(0, 0, route_at(33), 1); wr(0, 0, route_at(45), 1); wr(0, 0, route_at(60), 1);
        wr(1, 0, 12'h04C, 33); wr(1, 0, 12'h04C, 45); wr(1, 0, 12'h04C, 60);
        rd(1, 0, 12'h044, d);
        chk("R8 lowest of three", d, 33);
        src_i[33] = 1'b0;
        rd(1, 0, 12'h044, d);
        chk("R11 next after drop", d, 45);
        @(negedge clk);
        src_i[45] = 1'b0; src_i[60] = 1'b0;
        #1;
        chk("R11 irq follows level", 32'(irq_o), 0);
        rd(1, 0, 12'h044, d);
        chk("R8 none pending", d, 1023);
    endtask

    task automatic t_status_words();
        logic [31:0] d;
        do_reset();
        rd(0, 0, 12'h000, d);
        chk("R9 control word", d, 32'd256);
        ipi_i[2] = 1'b1; src_i[7] = 1'b1; src_i[40] = 1'b1;
        rd(1, 2, 12'h010, d);
        chk("R10 cause cpu2", d, 32'h81);
        rd(1, 1, 12'h010, d);
        chk("R10 cause cpu1", d, 32'h80);
        rd(0, 0, 12'h200, d);
        chk("R12 unmapped main", d, 0);
        rd(1, 0, 12'h048, d);
        chk("R12 unmapped per-cpu", d, 0);
        @(negedge clk);
        chk("R12 idle rdata", rdata, 0);
    endtask

    initial begin
        t_reset_and_gates();
        t_index_range();
        t_routing();
        t_private();
        t_priority_level();
        t_status_words();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule